// File: doc/BRIEF.md
# Activation Context Frame and Lane Allocator

This block manages the activation contexts of one processing element. It owns a pool of physical frames and, for each frame, a bitmap of free matching lanes. It also owns a table that maps every live activation ID to the frame and lane it holds. A control command does one of four things:

- claims a fresh frame;
- joins an existing activation's frame on a spare lane;
- releases an activation, handing its frame back once the last lane is gone;
- releases only the lane.

Each accepted command updates all state in one clock edge. It produces one response that carries the outcome, the frame and lane involved, and whether a physical frame went back to the pool.

Commands arrive on a valid/ready stream and responses leave on a valid/ready stream. Responses are registered, so the outcome appears in the cycle after acceptance. The command side accepts whenever the response register is empty or being drained in the same cycle. While `rsp_ready` is low, a pending response stays unchanged and no new command is taken. Two plain pulse outputs tell the neighbouring matching store to wipe the per-lane operand state of a released lane and, on a full release, the frame's slot contents.

Top module: `ctx_alloc`

## Requirements
- R1: After reset every frame is in the pool, every lane of every frame is free, no activation ID is mapped, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: A fresh-allocate command (`cmd_op` = 0) for an unmapped ID takes the lowest-numbered frame not in use, assigns lane 0, and leaves all other lanes of that frame free. When no frame is available it is rejected (`rsp_ok` = 0) and nothing changes.
- R3: A fresh-allocate or join command whose own `cmd_act` is already mapped is rejected and changes nothing.
- R4: A join command (`cmd_op` = 1) uses `cmd_parent` as the parent activation ID. It assigns the parent's frame and the lowest-indexed free lane of that frame.
- R5: A join command is rejected, with no state change, when the parent ID is unmapped or the parent's frame has no free lane.
- R6: A smart release (`cmd_op` = 2) of a mapped ID unmaps it and returns its lane. It reports that frame and lane, and it pulses `lane_clr_valid` with them in the response cycle. When other lanes of the frame remain in use, `rsp_frame_freed` is 0 and the frame stays out of the pool.
- R7: A smart release of the last lane in use also returns the frame to the pool, sets `rsp_frame_freed` to 1, and pulses `slot_clr_valid` with that frame.
- R8: A lane-only release (`cmd_op` = 3) unmaps the ID, returns the lane and pulses `lane_clr_valid`. It never returns the frame to the pool, even for the last lane, and `rsp_frame_freed` is always 0.
- R9: Either release command for an unmapped ID is rejected, emits no clear pulse and changes nothing.
- R10: A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` equals `!rsp_valid || rsp_ready`. The response appears one cycle after acceptance and is held unchanged while `rsp_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 2 | 0 fresh allocate, 1 join parent, 2 smart release, 3 lane-only release |
| cmd_act | input | 8 | Activation ID the command acts on |
| cmd_parent | input | 8 | Parent activation ID (join only) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle when valid |
| rsp_ok | output | 1 | 1 accepted, 0 rejected |
| rsp_frame | output | 3 | Frame assigned or released (0 on reject) |
| rsp_lane | output | 2 | Lane assigned or released (0 on reject) |
| rsp_frame_freed | output | 1 | Physical frame returned to the pool |
| lane_clr_valid | output | 1 | One-cycle request to wipe a lane's operand state |
| lane_clr_frame | output | 3 | Frame of the lane to wipe |
| lane_clr_lane | output | 2 | Lane to wipe |
| slot_clr_valid | output | 1 | One-cycle request to wipe a frame's slots |
| slot_clr_frame | output | 3 | Frame whose slots to wipe |

## Verification
The hardest situation to reach is a frame whose lanes run out while other frames are in odd states. One example is a frame left out of the pool with every lane free after a lane-only release; another is a partially shared frame that must not be returned by a smart release. The stimulus first exhausts the pool and the lanes of one frame in a fixed order. It then frees lanes out of order and drives a long pseudo-random phase over a small set of activation IDs, so that duplicates, orphaned parents and full frames keep recurring. Response back-pressure is applied at random throughout.

// File: rtl/ctx_alloc_pkg.sv
package ctx_alloc_pkg;
  typedef enum logic [1:0] {
    OP_FRESH     = 2'd0,
    OP_JOIN      = 2'd1,
    OP_RELEASE   = 2'd2,
    OP_DROP_LANE = 2'd3
  } ctx_op_e;
endpackage

// File: rtl/ctx_low_pick.sv
module ctx_low_pick #(
  parameter int WIDTH = 4,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

  logic [WIDTH-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (IW'(i) < idx) below_mask[i] = 1'b1;
    end
  end

  // R2 / R4: the granted index is a requested bit with nothing lower requested
  a_r4_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && ((req & below_mask) == '0)));
endmodule

// File: rtl/ctx_tag_table.sv
module ctx_tag_table #(
  parameter int ID_W = 8,
  parameter int FR_W = 3,
  parameter int LN_W = 2,
  localparam int DEPTH = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] rd_a_id,
  output logic            rd_a_hit,
  output logic [FR_W-1:0] rd_a_frame,
  output logic [LN_W-1:0] rd_a_lane,
  input  logic [ID_W-1:0] rd_b_id,
  output logic            rd_b_hit,
  output logic [FR_W-1:0] rd_b_frame,
  input  logic            set_en,
  input  logic [ID_W-1:0] set_id,
  input  logic [FR_W-1:0] set_frame,
  input  logic [LN_W-1:0] set_lane,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id
);
  logic [DEPTH-1:0] live_q;
  logic [FR_W-1:0]  frame_q [DEPTH];
  logic [LN_W-1:0]  lane_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else begin
      if (set_en) live_q[set_id] <= 1'b1;
      if (clr_en) live_q[clr_id] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) begin
      frame_q[set_id] <= set_frame;
      lane_q[set_id]  <= set_lane;
    end
  end

  assign rd_a_hit   = live_q[rd_a_id];
  assign rd_a_frame = frame_q[rd_a_id];
  assign rd_a_lane  = lane_q[rd_a_id];
  assign rd_b_hit   = live_q[rd_b_id];
  assign rd_b_frame = frame_q[rd_b_id];

  // R3: a mapping is never created over a live one
  a_r3_set_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !live_q[set_id]);
  // R9: only live mappings are removed
  a_r9_clear_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> live_q[clr_id]);
  // R10: one command per cycle touches the table once
  a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));
endmodule

// File: rtl/ctx_frame_pool.sv
module ctx_frame_pool #(
  parameter int NUM_FRAMES = 8,
  parameter int NUM_LANES  = 4,
  localparam int FR_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int LN_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 idle_any,
  output logic [FR_W-1:0]      idle_idx,
  input  logic [FR_W-1:0]      rd_a_frame,
  output logic [NUM_LANES-1:0] rd_a_lanes,
  input  logic [FR_W-1:0]      rd_b_frame,
  output logic [NUM_LANES-1:0] rd_b_lanes,
  input  logic                 take_en,
  input  logic [FR_W-1:0]      take_frame,
  input  logic                 grab_en,
  input  logic [FR_W-1:0]      grab_frame,
  input  logic [LN_W-1:0]      grab_lane,
  input  logic                 give_en,
  input  logic [FR_W-1:0]      give_frame,
  input  logic [LN_W-1:0]      give_lane,
  input  logic                 give_release
);
  localparam logic [NUM_LANES-1:0] LANE0 = NUM_LANES'(1);

  logic [NUM_FRAMES-1:0] busy_q;
  logic [NUM_LANES-1:0]  lanes_q [NUM_FRAMES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int f = 0; f < NUM_FRAMES; f++) lanes_q[f] <= '1;
    end else begin
      if (take_en) begin
        busy_q[take_frame]  <= 1'b1;
        lanes_q[take_frame] <= ~LANE0;
      end
      if (grab_en) lanes_q[grab_frame][grab_lane] <= 1'b0;
      if (give_en) begin
        lanes_q[give_frame][give_lane] <= 1'b1;
        if (give_release) busy_q[give_frame] <= 1'b0;
      end
    end
  end

  assign rd_a_lanes = lanes_q[rd_a_frame];
  assign rd_b_lanes = lanes_q[rd_b_frame];

  ctx_low_pick #(.WIDTH(NUM_FRAMES)) u_frame_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (~busy_q),
    .any   (idle_any),
    .idx   (idle_idx)
  );

  generate
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_idle_chk
      // R7: a frame sitting in the pool has every lane free
      a_r7_idle_all_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q[g] |-> (lanes_q[g] == '1));
    end
  endgenerate

  // R2: a fresh claim only takes a pooled frame
  a_r2_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |-> !busy_q[take_frame]);
  // R4: a join only takes a free lane of a frame in use
  a_r4_grab_free: assert property (@(posedge clk) disable iff (!rst_n)
    grab_en |-> (busy_q[grab_frame] && lanes_q[grab_frame][grab_lane]));
  // R6: a released lane was held and its frame was in use
  a_r6_give_held: assert property (@(posedge clk) disable iff (!rst_n)
    give_en |-> (busy_q[give_frame] && !lanes_q[give_frame][give_lane]));
endmodule

// File: rtl/ctx_alloc.sv
module ctx_alloc
  import ctx_alloc_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int NUM_LANES  = 4,
  parameter int ID_W       = 8,
  localparam int FR_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int LN_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [ID_W-1:0] cmd_act,
  input  logic [ID_W-1:0] cmd_parent,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_ok,
  output logic [FR_W-1:0] rsp_frame,
  output logic [LN_W-1:0] rsp_lane,
  output logic            rsp_frame_freed,
  output logic            lane_clr_valid,
  output logic [FR_W-1:0] lane_clr_frame,
  output logic [LN_W-1:0] lane_clr_lane,
  output logic            slot_clr_valid,
  output logic [FR_W-1:0] slot_clr_frame
);
  ctx_op_e op;
  assign op = ctx_op_e'(cmd_op);

  logic fire;
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  // table lookups
  logic            act_hit, par_hit;
  logic [FR_W-1:0] act_frame, par_frame;
  logic [LN_W-1:0] act_lane;

  // pool status
  logic                 idle_any;
  logic [FR_W-1:0]      idle_idx;
  logic [NUM_LANES-1:0] act_lanes, par_lanes;
  logic                 lane_any;
  logic [LN_W-1:0]      lane_idx;

  // decision
  logic            ok, freed, clr_lane;
  logic [FR_W-1:0] out_frame;
  logic [LN_W-1:0] out_lane;
  logic            set_en, clr_en, take_en, grab_en, give_en;
  logic [NUM_LANES-1:0] act_bit;

  always_comb begin
    act_bit = '0;
    act_bit[act_lane] = 1'b1;
  end

  always_comb begin
    ok        = 1'b0;
    freed     = 1'b0;
    clr_lane  = 1'b0;
    out_frame = '0;
    out_lane  = '0;
    set_en    = 1'b0;
    clr_en    = 1'b0;
    take_en   = 1'b0;
    grab_en   = 1'b0;
    give_en   = 1'b0;
    unique case (op)
      OP_FRESH: begin
        ok        = !act_hit && idle_any;
        out_frame = ok ? idle_idx : '0;
        take_en   = fire && ok;
        set_en    = fire && ok;
      end
      OP_JOIN: begin
        ok        = !act_hit && par_hit && lane_any;
        out_frame = ok ? par_frame : '0;
        out_lane  = ok ? lane_idx : '0;
        grab_en   = fire && ok;
        set_en    = fire && ok;
      end
      OP_RELEASE, OP_DROP_LANE: begin
        ok        = act_hit;
        out_frame = ok ? act_frame : '0;
        out_lane  = ok ? act_lane : '0;
        clr_lane  = ok;
        freed     = ok && (op == OP_RELEASE) && ((act_lanes | act_bit) == '1);
        give_en   = fire && ok;
        clr_en    = fire && ok;
      end
      default: ;
    endcase
  end

  ctx_tag_table #(.ID_W(ID_W), .FR_W(FR_W), .LN_W(LN_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_id    (cmd_act),
    .rd_a_hit   (act_hit),
    .rd_a_frame (act_frame),
    .rd_a_lane  (act_lane),
    .rd_b_id    (cmd_parent),
    .rd_b_hit   (par_hit),
    .rd_b_frame (par_frame),
    .set_en     (set_en),
    .set_id     (cmd_act),
    .set_frame  (out_frame),
    .set_lane   (out_lane),
    .clr_en     (clr_en),
    .clr_id     (cmd_act)
  );

  ctx_frame_pool #(.NUM_FRAMES(NUM_FRAMES), .NUM_LANES(NUM_LANES)) u_pool (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle_any     (idle_any),
    .idle_idx     (idle_idx),
    .rd_a_frame   (act_frame),
    .rd_a_lanes   (act_lanes),
    .rd_b_frame   (par_frame),
    .rd_b_lanes   (par_lanes),
    .take_en      (take_en),
    .take_frame   (idle_idx),
    .grab_en      (grab_en),
    .grab_frame   (par_frame),
    .grab_lane    (lane_idx),
    .give_en      (give_en),
    .give_frame   (act_frame),
    .give_lane    (act_lane),
    .give_release (freed)
  );

  ctx_low_pick #(.WIDTH(NUM_LANES)) u_lane_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (par_lanes),
    .any   (lane_any),
    .idx   (lane_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_ok          <= 1'b0;
      rsp_frame       <= '0;
      rsp_lane        <= '0;
      rsp_frame_freed <= 1'b0;
      lane_clr_valid  <= 1'b0;
      lane_clr_frame  <= '0;
      lane_clr_lane   <= '0;
      slot_clr_valid  <= 1'b0;
      slot_clr_frame  <= '0;
    end else begin
      lane_clr_valid <= fire && clr_lane;
      slot_clr_valid <= fire && freed;
      if (fire) begin
        rsp_valid       <= 1'b1;
        rsp_ok          <= ok;
        rsp_frame       <= out_frame;
        rsp_lane        <= out_lane;
        rsp_frame_freed <= freed;
        lane_clr_frame  <= out_frame;
        lane_clr_lane   <= out_lane;
        slot_clr_frame  <= out_frame;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R10: a stalled response is held unchanged
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid &&
      $stable({rsp_ok, rsp_frame, rsp_lane, rsp_frame_freed})));
  // R2: a successful fresh claim always returns lane 0
  a_r2_fresh_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_FRESH) |=> (!rsp_ok || rsp_lane == '0));
  // R8: a lane-only release never frees the frame
  a_r8_drop_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_DROP_LANE) |=> (!rsp_frame_freed && !slot_clr_valid));
endmodule

// File: tb/tb_ctx_alloc.sv
module tb_ctx_alloc;
  localparam int NF = 8;
  localparam int NL = 4;
  localparam int IDW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic           cmd_valid = 1'b0, cmd_ready;
  logic [1:0]     cmd_op = '0;
  logic [IDW-1:0] cmd_act = '0, cmd_parent = '0;
  logic           rsp_valid, rsp_ready = 1'b1, rsp_ok, rsp_frame_freed;
  logic [2:0]     rsp_frame, lane_clr_frame, slot_clr_frame;
  logic [1:0]     rsp_lane, lane_clr_lane;
  logic           lane_clr_valid, slot_clr_valid;

  ctx_alloc dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_act(cmd_act), .cmd_parent(cmd_parent),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .rsp_frame(rsp_frame), .rsp_lane(rsp_lane), .rsp_frame_freed(rsp_frame_freed),
    .lane_clr_valid(lane_clr_valid), .lane_clr_frame(lane_clr_frame),
    .lane_clr_lane(lane_clr_lane), .slot_clr_valid(slot_clr_valid),
    .slot_clr_frame(slot_clr_frame)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural model state
  bit m_map [256];
  int m_fr  [256];
  int m_ln  [256];
  bit m_busy[NF];
  int m_lanes[NF];
  localparam int ALL = (1 << NL) - 1;

  bit    e_v = 0, e_ok = 0, e_fd = 0, e_lc = 0, e_sc = 0;
  int    e_fr = 0, e_ln = 0;
  string e_tag = "R10";

  task automatic model_fire(int op, int act, int par);
    int f, l;
    e_ok = 0; e_fd = 0; e_fr = 0; e_ln = 0; e_lc = 0; e_sc = 0;
    case (op)
      0: begin
        if (m_map[act]) e_tag = "R3";
        else begin
          e_tag = "R2";
          f = -1;
          for (int i = NF - 1; i >= 0; i--) if (!m_busy[i]) f = i;
          if (f >= 0) begin
            m_busy[f] = 1; m_lanes[f] = ALL & ~1;
            m_map[act] = 1; m_fr[act] = f; m_ln[act] = 0;
            e_ok = 1; e_fr = f;
          end
        end
      end
      1: begin
        if (m_map[act]) e_tag = "R3";
        else if (!m_map[par]) e_tag = "R5";
        else begin
          f = m_fr[par]; l = -1;
          for (int i = NL - 1; i >= 0; i--) if (m_lanes[f][i]) l = i;
          if (l < 0) e_tag = "R5";
          else begin
            e_tag = "R4";
            m_lanes[f] &= ~(1 << l);
            m_map[act] = 1; m_fr[act] = f; m_ln[act] = l;
            e_ok = 1; e_fr = f; e_ln = l;
          end
        end
      end
      default: begin
        if (!m_map[act]) e_tag = "R9";
        else begin
          f = m_fr[act]; l = m_ln[act];
          m_map[act] = 0;
          m_lanes[f] |= (1 << l);
          e_ok = 1; e_fr = f; e_ln = l; e_lc = 1;
          if (op == 2 && m_lanes[f] == ALL) begin
            m_busy[f] = 0; e_fd = 1; e_sc = 1; e_tag = "R7";
          end else e_tag = (op == 2) ? "R6" : "R8";
        end
      end
    endcase
  endtask

  // command stream
  logic [17:0] q[$];
  task automatic push(int op, int act, int par);
    q.push_back({op[1:0], act[7:0], par[7:0]});
  endtask

  int unsigned rs = 32'h1234_5678;
  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  bit run = 0, done = 0, stall_mode = 0;
  bit have = 0;

  always @(negedge clk) begin
    if (run) begin
      int unsigned r;
      bit fire;
      chk("R10 rsp_valid", rsp_valid, e_v);
      chk("R10 cmd_ready", cmd_ready, !e_v || rsp_ready);
      if (e_v) begin
        chk({e_tag, " rsp_ok"}, rsp_ok, e_ok);
        if (e_ok) begin
          chk({e_tag, " rsp_frame"}, rsp_frame, e_fr);
          chk({e_tag, " rsp_lane"}, rsp_lane, e_ln);
        end
        chk({e_tag, " rsp_frame_freed"}, rsp_frame_freed, e_fd);
      end
      chk({e_tag, " lane_clr_valid"}, lane_clr_valid, e_lc);
      if (e_lc) begin
        chk("R6 lane_clr_frame", lane_clr_frame, e_fr);
        chk("R6 lane_clr_lane", lane_clr_lane, e_ln);
      end
      chk({e_tag, " slot_clr_valid"}, slot_clr_valid, e_sc);
      if (e_sc) chk("R7 slot_clr_frame", slot_clr_frame, e_fr);
      e_lc = 0; e_sc = 0;
      // next inputs
      r = rnd();
      rsp_ready = stall_mode ? (r[2:0] > 2) : 1'b1;
      if (!have && q.size() > 0 && !(stall_mode && r[5:3] == 0)) begin
        {cmd_op, cmd_act, cmd_parent} = q.pop_front();
        have = 1;
      end
      cmd_valid = have;
      fire = have && (!e_v || rsp_ready);
      if (e_v && rsp_ready) e_v = 0;
      if (fire) begin
        model_fire(cmd_op, cmd_act, cmd_parent);
        e_v = 1;
        have = 0;
      end
      if (!have && q.size() == 0 && !e_v && !fire) done = 1;
    end
  end

  int cyc = 0;
  bit wd_hit = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) wd_hit = 1;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_map[i] = 0; m_fr[i] = 0; m_ln[i] = 0; end
    for (int f = 0; f < NF; f++) begin m_busy[f] = 0; m_lanes[f] = ALL; end
    // directed
    push(2, 5, 0);                                  // R9 release of unmapped
    push(3, 6, 0);                                  // R9 lane-only of unmapped
    for (int i = 1; i <= NF; i++) push(0, i, 0);    // R2 frames 0..7
    push(0, 9, 0);                                  // R2 pool empty
    push(0, 1, 0);                                  // R3 duplicate
    push(1, 20, 1); push(1, 21, 1); push(1, 22, 1); // R4 lanes 1..3
    push(1, 23, 1);                                 // R5 no lane
    push(1, 24, 99);                                // R5 unmapped parent
    push(1, 2, 3);                                  // R3 join with mapped id
    push(2, 21, 0);                                 // R6 partial release
    push(1, 25, 20);                                // R4 lowest lane again
    push(3, 2, 0);                                  // R8 last lane kept
    push(0, 9, 0);                                  // R8 frame not pooled
    push(2, 1, 0); push(2, 20, 0); push(2, 22, 0);  // R6
    push(2, 25, 0);                                 // R7 last lane
    push(0, 9, 0);                                  // R2 takes frame 0
    for (int k = 0; k < 3000; k++) begin
      int unsigned a = rnd();
      push(a[1:0], 1 + (a[7:4] % 12), 1 + (a[11:8] % 12));
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 lane_clr_valid", lane_clr_valid, 0);
    chk("R1 slot_clr_valid", slot_clr_valid, 0);
    run = 1;
    wait (q.size() < 2500);
    stall_mode = 1;  // R10 random back-pressure
    wait (done || wd_hit);
    if (wd_hit && !done) begin
      n_tests++; n_fail++;
      $display("FAIL R10 watchdog: got 0 expected 1");
    end
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule